// File: doc/BRIEF.md
# Address ID Match Filter

This block decides whether a 16-bit address word recovered by a wake-up receiver is meant for this node. It holds a locally programmed ID whose top four bits name a group, and it compares every received ID against three address classes: the exact individual ID, a group address (same group nibble, remaining twelve bits zero) and the all-ones broadcast address. A 2-bit mode selects which of these classes are accepted.

Each received ID arrives with a valid strobe and a 2-bit band tag that says which of three frequency bands it came from. A per-band enable mask decides which bands are examined at all. One cycle after an accepted ID, the block raises a single-cycle match pulse for an interrupt unit and records the match reason and the band. These two values hold until the next accepted ID. A rejected ID on an enabled band raises a single-cycle fail strobe that carries the ID-fail exit code for a decoder exit-condition register. Configuration is written through a small byte-wide write port.

Top module: `id_match_filter`

## Requirements
- R1: After reset, the local ID is 0x7DA8, the mode is 0, all three band enables are set, last_band is 3 (none), last_reason is 0, and match_pulse, fail_valid and fail_code are 0.
- R2: A write with cfg_we=1 updates one setting. Offset 0 sets ID bits 15:8 and offset 1 sets ID bits 7:0. Offset 2 sets the enable mask from wdata[2:0], with bit 0 for 433 MHz, bit 1 for 868/915 MHz and bit 2 for 2.4 GHz. Offset 3 sets the mode from wdata[1:0]. An ID that arrives in the same cycle as a write is judged with the settings from before the write.
- R3: An individual match occurs when the received ID equals the local ID.
- R4: A group match occurs when received bits 15:12 equal local ID bits 15:12 and received bits 11:0 are all zero.
- R5: A broadcast match occurs when the received ID is 0xFFFF.
- R6: The mode sets which classes are accepted: 0 accepts individual only; 1 accepts individual or group; 2 accepts broadcast only; 3 accepts all three.
- R7: The reason code is 1 for individual, 2 for group and 3 for broadcast. When several accepted classes hold at once, the lowest code wins.
- R8: On an accepted ID, last_band takes the band tag (0 = 433 MHz, 1 = 868/915 MHz, 2 = 2.4 GHz) and last_reason takes the reason, one cycle after the strobe. Both then hold until the next accepted ID.
- R9: An ID with a band tag of 3, or on a band whose enable bit is clear, is ignored. It raises no match pulse and no fail strobe, and it leaves last_band and last_reason unchanged.
- R10: An ID on an enabled band that no accepted class matches raises fail_valid for one cycle with fail_code = 2, one cycle after the strobe. fail_code is 0 at all other times. last_band and last_reason are left unchanged.
- R11: Each accepted ID produces exactly one cycle of match_pulse, one cycle after its strobe. Back-to-back accepted IDs produce back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration offset |
| cfg_wdata | input | 8 | Configuration write data |
| rx_valid | input | 1 | Received ID strobe |
| rx_id | input | 16 | Received address word |
| rx_band | input | 2 | Band tag of the received ID |
| match_pulse | output | 1 | One-cycle pulse on an accepted ID |
| fail_valid | output | 1 | One-cycle strobe on a rejected ID |
| fail_code | output | 2 | Exit-condition code, 2 during fail_valid |
| last_band | output | 2 | Band of the most recent accepted ID, 3 if none |
| last_reason | output | 2 | Reason of the most recent accepted ID |

## Verification
The bench targets addresses that qualify for several classes at once: a local ID of 0xFFFF, and a local ID whose low twelve bits are zero. A design with the wrong priority would report a group or broadcast reason where the individual reason is due. It sends group-shaped and broadcast addresses under every mode, so that a mode decoder with crossed encodings would either accept them or fail them wrongly. It sends IDs on disabled bands and with band tag 3. Here a design that used the tag as an unchecked index, or let an ignored ID disturb state, would emit a fail strobe or overwrite the held band and reason. Writes that coincide with a received ID, and back-to-back strobes, expose a design that samples settings a cycle late or merges adjacent pulses.

// File: rtl/idm_pkg.sv
package idm_pkg;
  localparam int ID_W   = 16;
  localparam int BYTE_W = 8;
  localparam int GRP_W  = 4;
  localparam int BAND_N = 3;
  localparam int TAG_W  = 2;
  localparam int LOW_W  = ID_W - GRP_W;

  typedef enum logic [1:0] {
    MODE_IND     = 2'd0,
    MODE_IND_GRP = 2'd1,
    MODE_BCAST   = 2'd2,
    MODE_ALL     = 2'd3
  } idm_mode_e;

  typedef enum logic [1:0] {
    RSN_NONE  = 2'd0,
    RSN_IND   = 2'd1,
    RSN_GRP   = 2'd2,
    RSN_BCAST = 2'd3
  } idm_reason_e;

  localparam logic [TAG_W-1:0] BAND_NONE    = 2'd3;
  localparam logic [1:0]       EXIT_ID_FAIL = 2'd2;
  localparam logic [ID_W-1:0]  BCAST_ID     = '1;

  localparam logic [1:0] OFS_ID_HI = 2'd0;
  localparam logic [1:0] OFS_ID_LO = 2'd1;
  localparam logic [1:0] OFS_BANDS = 2'd2;
  localparam logic [1:0] OFS_MODE  = 2'd3;

  function automatic logic is_group(input logic [ID_W-1:0] rx, input logic [ID_W-1:0] own);
    return (rx[ID_W-1 -: GRP_W] == own[ID_W-1 -: GRP_W]) && (rx[LOW_W-1:0] == '0);
  endfunction

  function automatic idm_reason_e pick_reason(input logic ind, input logic grp,
                                             input logic bc, input idm_mode_e mode);
    logic ok_ind, ok_grp, ok_bc;
    ok_ind = ind && (mode != MODE_BCAST);
    ok_grp = grp && (mode == MODE_IND_GRP || mode == MODE_ALL);
    ok_bc  = bc  && (mode == MODE_BCAST   || mode == MODE_ALL);
    if (ok_ind)      return RSN_IND;
    else if (ok_grp) return RSN_GRP;
    else if (ok_bc)  return RSN_BCAST;
    else             return RSN_NONE;
  endfunction
endpackage

// File: rtl/idm_cfg_regs.sv
module idm_cfg_regs
  import idm_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [ID_W-1:0] RESET_ID = 16'h7DA8,
  parameter logic [BAND_N-1:0] RESET_EN = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [ID_W-1:0]     own_id,
  output logic [BAND_N-1:0]   band_en,
  output idm_mode_e           mode
);
  localparam int NBYTES = ID_W / BYTE_W;

  logic [NBYTES-1:0] byte_wr;

  // offset 0 holds the upper byte, so the byte index counts down from it
  for (genvar g = 0; g < NBYTES; g++) begin : g_id_byte
    localparam int OFS = NBYTES - 1 - g;
    assign byte_wr[g] = we && (addr == ADDR_W'(OFS));
    always_ff @(posedge clk) begin
      if (!rst_n)          own_id[g*BYTE_W +: BYTE_W] <= RESET_ID[g*BYTE_W +: BYTE_W];
      else if (byte_wr[g]) own_id[g*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      band_en <= RESET_EN;
      mode    <= MODE_IND;
    end else if (we) begin
      if (addr == ADDR_W'(OFS_BANDS)) band_en <= wdata[BAND_N-1:0];
      if (addr == ADDR_W'(OFS_MODE))  mode    <= idm_mode_e'(wdata[1:0]);
    end
  end

  // R2: a write to offset 2 lands in the mask on the next cycle
  a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(OFS_BANDS)) |=> (band_en == $past(wdata[BAND_N-1:0])));
endmodule

// File: rtl/idm_classifier.sv
module idm_classifier
  import idm_pkg::*;
(
  input  logic              rx_valid,
  input  logic [ID_W-1:0]   rx_id,
  input  logic [TAG_W-1:0]  rx_band,
  input  logic [ID_W-1:0]   own_id,
  input  logic [BAND_N-1:0] band_en,
  input  idm_mode_e         mode,
  output logic              band_ok,
  output logic              hit,
  output logic              miss,
  output idm_reason_e       reason
);
  logic [BAND_N-1:0] band_sel;
  logic ind_eq, grp_eq, bc_eq;

  for (genvar b = 0; b < BAND_N; b++) begin : g_band
    assign band_sel[b] = (rx_band == TAG_W'(b)) && band_en[b];
  end

  assign band_ok = |band_sel;
  assign ind_eq  = (rx_id == own_id);
  assign grp_eq  = is_group(rx_id, own_id);
  assign bc_eq   = (rx_id == BCAST_ID);
  assign reason  = pick_reason(ind_eq, grp_eq, bc_eq, mode);
  assign hit     = rx_valid && band_ok && (reason != RSN_NONE);
  assign miss    = rx_valid && band_ok && (reason == RSN_NONE);
endmodule

// File: rtl/idm_result_regs.sv
module idm_result_regs
  import idm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              miss,
  input  idm_reason_e       reason,
  input  logic [TAG_W-1:0]  band,
  output logic              match_pulse,
  output logic              fail_valid,
  output logic [1:0]        fail_code,
  output logic [TAG_W-1:0]  last_band,
  output idm_reason_e       last_reason
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_pulse <= 1'b0;
      fail_valid  <= 1'b0;
      fail_code   <= 2'd0;
      last_band   <= BAND_NONE;
      last_reason <= RSN_NONE;
    end else begin
      match_pulse <= hit;
      fail_valid  <= miss;
      fail_code   <= miss ? EXIT_ID_FAIL : 2'd0;
      if (hit) begin
        last_band   <= band;
        last_reason <= reason;
      end
    end
  end

  // R10: the fail strobe always carries the ID-fail code
  a_r10_fail_code: assert property (@(posedge clk) disable iff (!rst_n)
    fail_valid |-> (fail_code == EXIT_ID_FAIL));
  // R11: pass and fail never coincide
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_pulse && fail_valid));
  // R8: a match always leaves a real band and reason behind
  a_r8_valid_record: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> (last_band != BAND_NONE && last_reason != RSN_NONE));
  // R8: record holds when no new accepted ID arrived
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(last_band) && $stable(last_reason)));
endmodule

// File: rtl/id_match_filter.sv
module id_match_filter
  import idm_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [ID_W-1:0] RESET_ID = 16'h7DA8,
  parameter logic [BAND_N-1:0] RESET_EN = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              rx_valid,
  input  logic [15:0]       rx_id,
  input  logic [1:0]        rx_band,
  output logic              match_pulse,
  output logic              fail_valid,
  output logic [1:0]        fail_code,
  output logic [1:0]        last_band,
  output logic [1:0]        last_reason
);
  logic [ID_W-1:0]   own_id;
  logic [BAND_N-1:0] band_en;
  idm_mode_e         mode;
  logic              band_ok, hit, miss;
  idm_reason_e       reason, held_reason;

  idm_cfg_regs #(.ADDR_W(ADDR_W), .RESET_ID(RESET_ID), .RESET_EN(RESET_EN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .own_id(own_id), .band_en(band_en), .mode(mode)
  );

  idm_classifier u_cls (
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_band(rx_band), .own_id(own_id),
    .band_en(band_en), .mode(mode), .band_ok(band_ok), .hit(hit), .miss(miss),
    .reason(reason)
  );

  idm_result_regs u_res (
    .clk(clk), .rst_n(rst_n), .hit(hit), .miss(miss), .reason(reason), .band(rx_band),
    .match_pulse(match_pulse), .fail_valid(fail_valid), .fail_code(fail_code),
    .last_band(last_band), .last_reason(held_reason)
  );

  assign last_reason = held_reason;

  // R9: ignored IDs produce no strobe of either kind
  a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !band_ok) |=> (!match_pulse && !fail_valid));
  // R11: a match pulse only follows a strobe
  a_r11_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(rx_valid));
endmodule

// File: tb/id_match_filter_tb_top.sv
module id_match_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic rx_valid = 1'b0;
  logic [15:0] rx_id = '0;
  logic [1:0] rx_band = '0;
  logic match_pulse, fail_valid;
  logic [1:0] fail_code, last_band, last_reason;

  always #2.5 clk = ~clk;

  id_match_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_band(rx_band), .match_pulse(match_pulse),
    .fail_valid(fail_valid), .fail_code(fail_code), .last_band(last_band),
    .last_reason(last_reason)
  );

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  // behavioural reference model
  int m_id, m_en, m_mode, e_pulse, e_fail, e_code, e_band, e_reason;

  function automatic int ref_reason(int rx, int id, int mode);
    bit ind = (rx == id);
    bit grp = ((rx / 4096) == (id / 4096)) && ((rx % 4096) == 0);
    bit bc  = (rx == 65535);
    case (mode)
      0: return ind ? 1 : 0;
      1: return ind ? 1 : (grp ? 2 : 0);
      2: return bc ? 3 : 0;
      default: return ind ? 1 : (grp ? 2 : (bc ? 3 : 0));
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_id = 32'h7DA8; m_en = 7; m_mode = 0;
      e_pulse = 0; e_fail = 0; e_code = 0; e_band = 3; e_reason = 0;
    end else begin
      int r;
      e_pulse = 0; e_fail = 0; e_code = 0;
      if (rx_valid && rx_band != 3 && ((m_en >> rx_band) & 1) == 1) begin
        r = ref_reason(int'(rx_id), m_id, m_mode);
        if (r != 0) begin e_pulse = 1; e_band = rx_band; e_reason = r; end
        else begin e_fail = 1; e_code = 2; end
      end
      if (cfg_we) begin
        case (cfg_addr)
          0: m_id = (m_id % 256) + int'(cfg_wdata) * 256;
          1: m_id = (m_id / 256) * 256 + int'(cfg_wdata);
          2: m_id = m_id;
          default: m_id = m_id;
        endcase
        if (cfg_addr == 2) m_en = int'(cfg_wdata) % 8;
        if (cfg_addr == 3) m_mode = int'(cfg_wdata) % 4;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // compare every cycle, away from the edge
  always @(negedge clk) if (rst_n) begin
    chk("match_pulse", int'(match_pulse), e_pulse);
    chk("fail_valid",  int'(fail_valid),  e_fail);
    chk("fail_code",   int'(fail_code),   e_code);
    chk("last_band",   int'(last_band),   e_band);
    chk("last_reason", int'(last_reason), e_reason);
  end

  task automatic wr(int a, int d);
    @(negedge clk); cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = 8'(d);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send(int id, int band);
    @(negedge clk); rx_valid = 1; rx_id = 16'(id); rx_band = 2'(band);
    @(negedge clk); rx_valid = 0;
  endtask

  // directed check on top of the per-cycle compare
  task automatic expect_now(int p, int f, int b, int r);
    chk("dir pulse", int'(match_pulse), p);
    chk("dir fail", int'(fail_valid), f);
    chk("dir band", int'(last_band), b);
    chk("dir reason", int'(last_reason), r);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        tag = "R1"; expect_now(0, 0, 3, 0);
        tag = "R3"; send(16'h7DA8, 0); expect_now(1, 0, 0, 1);
        tag = "R11"; @(negedge clk); expect_now(0, 0, 0, 1);
        tag = "R10"; send(16'h7000, 1); expect_now(0, 1, 0, 1);
        chk("R10 code", int'(fail_code), 2);
        tag = "R6"; wr(3, 1);
        tag = "R4"; send(16'h7000, 1); expect_now(1, 0, 1, 2);
        send(16'h7001, 1); expect_now(0, 1, 1, 2);
        tag = "R5"; send(16'hFFFF, 2); expect_now(0, 1, 1, 2);
        wr(3, 2); send(16'hFFFF, 2); expect_now(1, 0, 2, 3);
        tag = "R6"; send(16'h7DA8, 0); expect_now(0, 1, 2, 3);
        tag = "R7"; wr(0, 8'hFF); wr(1, 8'hFF); wr(3, 3);
        send(16'hFFFF, 0); expect_now(1, 0, 0, 1);
        wr(0, 8'h70); wr(1, 8'h00); send(16'h7000, 2); expect_now(1, 0, 2, 1);
        wr(1, 8'h05); send(16'h7000, 1); expect_now(1, 0, 1, 2);
        tag = "R9"; wr(2, 3'b101);
        send(16'h7005, 1); expect_now(0, 0, 1, 2);
        send(16'h7005, 3); expect_now(0, 0, 1, 2);
        send(16'h7005, 2); expect_now(1, 0, 2, 1);
        tag = "R2"; @(negedge clk);
        cfg_we = 1; cfg_addr = 3; cfg_wdata = 8'h00;
        rx_valid = 1; rx_id = 16'hFFFF; rx_band = 0;
        @(negedge clk); cfg_we = 0; rx_valid = 0; expect_now(1, 0, 0, 3);
        tag = "R11"; @(negedge clk);
        rx_valid = 1; rx_id = 16'h7005; rx_band = 0;
        @(negedge clk); rx_band = 2;
        chk("R11 first", int'(match_pulse), 1);
        @(negedge clk); rx_valid = 0;
        chk("R11 second", int'(match_pulse), 1);
        chk("R11 band", int'(last_band), 2);
        @(negedge clk); chk("R11 end", int'(match_pulse), 0);
        tag = "R8"; repeat (5) @(negedge clk); expect_now(0, 0, 2, 1);
        tag = "R6";
        for (int i = 0; i < 2000; i++) begin
          @(negedge clk);
          cfg_we = ($urandom_range(0, 7) == 0);
          cfg_addr = 2'($urandom_range(0, 3));
          cfg_wdata = 8'($urandom_range(0, 255));
          rx_valid = ($urandom_range(0, 1) == 1);
          case ($urandom_range(0, 3))
            0: rx_id = 16'hFFFF;
            1: rx_id = {4'($urandom_range(6, 8)), 12'h000};
            2: rx_id = 16'h7005;
            default: rx_id = 16'($urandom_range(0, 65535));
          endcase
          rx_band = 2'($urandom_range(0, 3));
        end
        @(negedge clk); cfg_we = 0; rx_valid = 0;
        tag = "R1"; rst_n = 0; @(negedge clk); rst_n = 1;
        @(negedge clk); expect_now(0, 0, 3, 0);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule